// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Fast-Interrupt Output

This block collects thirty-two level-sensitive interrupt sources. It also keeps a software-owned pending word, and it presents both to a processor through a small 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. The hardware levels and the software pending bits are merged into one raw vector. Two independent enable words gate that vector. Each enable word is changed only through a write-one-to-set offset and a write-one-to-clear offset. One gated result drives the normal interrupt line and the other drives the fast-interrupt line. Each line is a registered OR of its gated vector.

Software acknowledges a source by clearing its enable bit, because a level source stays pending for as long as its input is high. To find work, the handler reads a masked-status word and scans it from the least significant bit, repeating until the word reads zero. Controllers can be cascaded, with the interrupt line of this block wired to one input of a parent.

When the block is built as a secondary controller, it holds an extra pass-through word. A write to offset 0x20 loads that word. A bypass vector then forwards the selected raw sources directly to the primary controller, with no clocked stage.

Top module: `lvl_intc`

## Requirements
- R1: A synchronous reset clears both enable words, the software pending word and the pass-through word, and it drives `irq_o`, `fiq_o` and `bypass_o` to zero.
- R2: A write to 0x08 sets each normal-interrupt enable bit whose write-data bit is 1, and a write to 0x28 does the same for the fast-interrupt enable word. All other bits are left unchanged.
- R3: A write to 0x0C clears each normal-interrupt enable bit whose write-data bit is 1, and a write to 0x2C does the same for the fast-interrupt enable word. All other bits are left unchanged.
- R4: A write to 0x10 sets the software pending bits marked 1 in the data, and a write to 0x14 clears them. The software pending word is ORed into the raw vector.
- R5: Reads of 0x04 and 0x24 both return the raw vector, (source levels OR software pending) AND the valid mask. The raw vector follows the input levels in the same cycle.
- R6: A read of 0x00 returns the raw vector AND the normal enable word, and a read of 0x20 returns the raw vector AND the fast enable word. Each reads as zero when no enabled source is pending.
- R7: `irq_o` equals the OR of the normal masked status from the previous clock, and `fiq_o` equals the OR of the fast masked status from the previous clock.
- R8: Reads of 0x08 and 0x0C return the normal enable word, reads of 0x28 and 0x2C return the fast enable word, and reads of 0x10 and 0x14 return the software pending word. Every other offset reads as zero.
- R9: Bits that are clear in the `VALID_SRC` parameter always read as zero in the raw vector, in both enable words and in the software pending word, whatever is written or driven.
- R10: In secondary mode, a write to 0x20 loads the pass-through word. `bypass_o` equals the raw vector AND the pass-through word, with no clock delay. With the value 0xFFD00000, sources 20 and 22 to 31 are forwarded.
- R11: Writes to 0x00, 0x04, 0x24 and to undefined offsets change no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | 32 | Level inputs, one per source |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |
| bypass_o | output | 32 | Pass-through sources for a primary controller (zero unless in secondary mode) |

## Verification
The bench aims at the one-cycle lag of the request lines. A design that drove them combinationally, or with two stages, would assert `irq_o` a cycle early or a cycle late after an enable write. It also checks that a set write and a clear write touch only the bits marked 1. An implementation that loaded the word directly would wipe neighbouring enables, which is visible when the enables are read back. Writes to the status offsets must not be taken as enable writes. In secondary mode, a write to 0x20 must land in the pass-through word and not in the fast enable word. Finally, the bench drives an unimplemented source and sets its enable. A design that ignored `VALID_SRC` would report that bit in the raw status and raise a request for it.

// File: rtl/lvl_intc_pkg.sv
package lvl_intc_pkg;

    localparam int SRC_N  = 32;
    localparam int ADDR_W = 8;

    typedef logic [SRC_N-1:0]  vec_t;
    typedef logic [ADDR_W-1:0] ofs_t;

    // Register offsets that software decodes.
    typedef enum logic [ADDR_W-1:0] {
        OFS_IRQ_MSK   = 8'h00,
        OFS_IRQ_RAW   = 8'h04,
        OFS_IRQ_ENSET = 8'h08,
        OFS_IRQ_ENCLR = 8'h0C,
        OFS_SW_SET    = 8'h10,
        OFS_SW_CLR    = 8'h14,
        OFS_FIQ_MSK   = 8'h20,
        OFS_FIQ_RAW   = 8'h24,
        OFS_FIQ_ENSET = 8'h28,
        OFS_FIQ_ENCLR = 8'h2C
    } reg_ofs_e;

    typedef struct packed {
        logic irq_set;
        logic irq_clr;
        logic sw_set;
        logic sw_clr;
        logic fiq_set;
        logic fiq_clr;
        logic pt_load;
    } wr_strobe_t;

    typedef struct packed {
        vec_t raw;
        vec_t irq_en;
        vec_t fiq_en;
        vec_t sw_pend;
    } reg_view_t;

    function automatic wr_strobe_t decode_wr(logic we, ofs_t a, logic secondary);
        wr_strobe_t s;
        s = '0;
        if (we) begin
            case (a)
                OFS_IRQ_ENSET: s.irq_set = 1'b1;
                OFS_IRQ_ENCLR: s.irq_clr = 1'b1;
                OFS_SW_SET:    s.sw_set  = 1'b1;
                OFS_SW_CLR:    s.sw_clr  = 1'b1;
                OFS_FIQ_ENSET: s.fiq_set = 1'b1;
                OFS_FIQ_ENCLR: s.fiq_clr = 1'b1;
                OFS_FIQ_MSK:   s.pt_load = secondary;
                default:       s = '0;
            endcase
        end
        return s;
    endfunction

    function automatic vec_t read_word(ofs_t a, reg_view_t v);
        vec_t d;
        case (a)
            OFS_IRQ_MSK:                 d = v.raw & v.irq_en;
            OFS_IRQ_RAW, OFS_FIQ_RAW:    d = v.raw;
            OFS_IRQ_ENSET, OFS_IRQ_ENCLR: d = v.irq_en;
            OFS_SW_SET, OFS_SW_CLR:      d = v.sw_pend;
            OFS_FIQ_MSK:                 d = v.raw & v.fiq_en;
            OFS_FIQ_ENSET, OFS_FIQ_ENCLR: d = v.fiq_en;
            default:                     d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/lvl_intc_bitreg.sv
module lvl_intc_bitreg #(
    parameter int           W    = 32,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else if (set_en) begin
            q_r <= (q_r | wdata) & KEEP;
        end else if (clr_en) begin
            q_r <= q_r & ~wdata;
        end
    end

    assign q = q_r;

    AST_SET_MARKED: assert property (@(posedge clk) disable iff (rst)
        set_en |=> ((q & $past(wdata & KEEP)) == $past(wdata & KEEP))); // R2
    AST_CLR_MARKED: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> ((q & $past(wdata)) == '0)); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!set_en && !clr_en) |=> $stable(q)); // R11
    AST_VALID_ONLY: assert property (@(posedge clk) disable iff (rst)
        set_en |=> ((q & ~KEEP) == '0)); // R9

endmodule

// File: rtl/lvl_intc_rdmux.sv
module lvl_intc_rdmux
    import lvl_intc_pkg::*;
(
    input  ofs_t      addr,
    input  reg_view_t view,
    output vec_t      rdata
);

    always_comb begin
        rdata = read_word(addr, view);
    end

endmodule

// File: rtl/lvl_intc.sv
module lvl_intc
    import lvl_intc_pkg::*;
#(
    parameter logic [SRC_N-1:0] VALID_SRC = '1,
    parameter bit               SECONDARY = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_N-1:0]  src_lvl,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [SRC_N-1:0]  bus_wdata,
    output logic [SRC_N-1:0]  bus_rdata,
    output logic              irq_o,
    output logic              fiq_o,
    output logic [SRC_N-1:0]  bypass_o
);

    wr_strobe_t stb;
    vec_t       irq_en, fiq_en, sw_pend;
    vec_t       raw, irq_pend, fiq_pend;
    reg_view_t  view;
    logic       irq_q, fiq_q;

    assign stb = decode_wr(bus_we, bus_addr, SECONDARY);

    lvl_intc_bitreg #(.W(SRC_N), .KEEP(VALID_SRC)) u_irq_en (
        .clk(clk), .rst(rst), .set_en(stb.irq_set), .clr_en(stb.irq_clr),
        .wdata(bus_wdata), .q(irq_en));

    lvl_intc_bitreg #(.W(SRC_N), .KEEP(VALID_SRC)) u_fiq_en (
        .clk(clk), .rst(rst), .set_en(stb.fiq_set), .clr_en(stb.fiq_clr),
        .wdata(bus_wdata), .q(fiq_en));

    lvl_intc_bitreg #(.W(SRC_N), .KEEP(VALID_SRC)) u_sw_pend (
        .clk(clk), .rst(rst), .set_en(stb.sw_set), .clr_en(stb.sw_clr),
        .wdata(bus_wdata), .q(sw_pend));

    assign raw      = (src_lvl | sw_pend) & VALID_SRC;
    assign irq_pend = raw & irq_en;
    assign fiq_pend = raw & fiq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            fiq_q <= 1'b0;
        end else begin
            irq_q <= |irq_pend;
            fiq_q <= |fiq_pend;
        end
    end

    assign irq_o = irq_q;
    assign fiq_o = fiq_q;

    assign view = '{raw: raw, irq_en: irq_en, fiq_en: fiq_en, sw_pend: sw_pend};

    lvl_intc_rdmux u_rd (
        .addr(bus_addr), .view(view), .rdata(bus_rdata));

    generate
        if (SECONDARY) begin : g_sec
            vec_t pt_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    pt_q <= '0;
                end else if (stb.pt_load) begin
                    pt_q <= bus_wdata;
                end
            end
            assign bypass_o = raw & pt_q;

            AST_PT_LOADED: assert property (@(posedge clk) disable iff (rst)
                stb.pt_load |=> (pt_q == $past(bus_wdata))); // R10
        end else begin : g_pri
            assign bypass_o = '0;
        end
    endgenerate

    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq_o == |$past(irq_pend))); // R7
    AST_FIQ_LAG: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (fiq_o == |$past(fiq_pend))); // R7
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!irq_o && !fiq_o)); // R1

endmodule

// File: tb/lvl_intc_test.sv
module lvl_intc_test;

    localparam logic [31:0] VALID = 32'hEFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src = '0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wd = '0;
    logic [31:0] rdata, bypass;
    logic        irq, fiq;

    int checks = 0;
    int errors = 0;
    bit live = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lvl_intc #(.VALID_SRC(VALID), .SECONDARY(1'b1)) uut (
        .clk(clk), .rst(rst), .src_lvl(src), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wd), .bus_rdata(rdata), .irq_o(irq), .fiq_o(fiq),
        .bypass_o(bypass));

    // Behavioural reference state
    logic [31:0] m_ien = '0, m_fen = '0, m_sw = '0, m_pt = '0;
    logic        m_irq = 1'b0, m_fiq = 1'b0;

    function automatic logic [31:0] m_raw();
        return (src | m_sw) & VALID;
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        case (a)
            8'h00: return m_raw() & m_ien;
            8'h04, 8'h24: return m_raw();
            8'h08, 8'h0C: return m_ien;
            8'h10, 8'h14: return m_sw;
            8'h20: return m_raw() & m_fen;
            8'h28, 8'h2C: return m_fen;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(logic [7:0] a);
        case (a)
            8'h00, 8'h20: return "R6";
            8'h04, 8'h24: return "R5";
            default:      return "R8";
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ien <= '0; m_fen <= '0; m_sw <= '0; m_pt <= '0;
            m_irq <= 1'b0; m_fiq <= 1'b0;
        end else begin
            m_irq <= |(m_raw() & m_ien);
            m_fiq <= |(m_raw() & m_fen);
            if (we) begin
                case (addr)
                    8'h08: m_ien <= (m_ien | wd) & VALID;
                    8'h0C: m_ien <= m_ien & ~wd;
                    8'h10: m_sw  <= (m_sw | wd) & VALID;
                    8'h14: m_sw  <= m_sw & ~wd;
                    8'h28: m_fen <= (m_fen | wd) & VALID;
                    8'h2C: m_fen <= m_fen & ~wd;
                    8'h20: m_pt  <= wd;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Full comparison against the model every cycle, between edges
    always @(negedge clk) begin
        if (live && !rst) begin
            chk(tag_of(addr), rdata, m_read(addr));
            chk("R7 irq", {31'b0, irq}, {31'b0, m_irq});
            chk("R7 fiq", {31'b0, fiq}, {31'b0, m_fiq});
            chk("R10 bypass", bypass, m_raw() & m_pt);
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        addr = a; wd = d; we = 1'b1;
        step();
        we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        addr = a; we = 1'b0;
        @(negedge clk);
        chk(tag, rdata, exp);
        step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] ofs_list [12];
        ofs_list = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14,
                     8'h18, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30};
        repeat (3) step();
        rst = 1'b0;
        live = 1'b1;
        step();
        // R1: reset state
        @(negedge clk);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 fiq", {31'b0, fiq}, 32'h0);
        chk("R1 bypass", bypass, 32'h0);
        step();
        rd(8'h08, 32'h0, "R1 irq enable");
        rd(8'h28, 32'h0, "R1 fiq enable");
        rd(8'h10, 32'h0, "R1 soft pending");

        // R2 and R9: set all, unimplemented bit 28 stays clear
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, 32'hEFFF_FFFF, "R2 R9 enable set");
        // R3: clear only marked bits
        wr(8'h0C, 32'h0000_FFFF);
        rd(8'h0C, 32'hEFFF_0000, "R3 R8 enable clear");

        // R5 R6: level source with enable off, then on
        src = 32'h0000_0100;
        rd(8'h04, 32'h0000_0100, "R5 raw");
        rd(8'h24, 32'h0000_0100, "R5 raw alias");
        rd(8'h00, 32'h0, "R6 masked zero");
        src = 32'h0001_0100;
        rd(8'h00, 32'h0001_0000, "R6 masked");
        chk("R7 irq high", {31'b0, irq}, 32'h1);

        // R9: unimplemented source never appears
        src = 32'h1000_0000;
        rd(8'h04, 32'h0, "R9 raw masked");
        chk("R9 no request", {31'b0, irq}, 32'h0);

        // R4: software pending
        src = '0;
        wr(8'h10, 32'h1000_0005);
        rd(8'h10, 32'h0000_0005, "R4 R9 soft set");
        rd(8'h04, 32'h0000_0005, "R4 soft in raw");
        wr(8'h14, 32'h0000_0001);
        rd(8'h14, 32'h0000_0004, "R4 soft clear");

        // R7: exact lag of fiq after enable write (bit 2 pending)
        addr = 8'h28; wd = 32'h4; we = 1'b1;
        step();
        we = 1'b0;
        @(negedge clk);
        chk("R7 fiq not yet", {31'b0, fiq}, 32'h0);
        @(negedge clk);
        chk("R7 fiq one later", {31'b0, fiq}, 32'h1);
        step();
        rd(8'h20, 32'h4, "R6 fiq masked");
        wr(8'h2C, 32'h4);
        step();
        @(negedge clk);
        chk("R3 fiq cleared", {31'b0, fiq}, 32'h0);
        step();
        wr(8'h14, 32'hFFFF_FFFF);

        // R11: writes to read-only and undefined offsets
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h08, 32'hEFFF_0000, "R11 irq enable kept");
        rd(8'h28, 32'h0, "R11 fiq enable kept");
        rd(8'h10, 32'h0, "R11 soft kept");

        // R8: undefined offsets read zero
        src = 32'hFFFF_FFFF;
        rd(8'h18, 32'h0, "R8 undefined 18");
        rd(8'h30, 32'h0, "R8 undefined 30");

        // R10: pass-through load, fiq enable untouched
        wr(8'h20, 32'hFFD0_0000);
        @(negedge clk);
        chk("R10 bypass", bypass, 32'hEFD0_0000);
        step();
        rd(8'h28, 32'h0, "R10 fiq enable untouched");
        src = 32'h0010_0000;
        @(negedge clk);
        chk("R10 bypass same cycle", bypass, 32'h0010_0000);
        step();
        src = '0;

        // Mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            addr = ofs_list[$urandom_range(0, 11)];
            we   = ($urandom_range(0, 2) == 0);
            wd   = $urandom;
            if ($urandom_range(0, 3) == 0) src = $urandom & $urandom;
            step();
        end
        we = 1'b0;
        step();
        finish_run();
    end

endmodule